// File: doc/BRIEF.md
# Configuration Image Checksum Validator

This block validates a configuration image held in an external word-wide memory before the rest of the chip trusts it. After a start pulse it reads the image one 16-bit word per clock through a read port whose data returns a fixed number of cycles after the request. It folds the bytes into an 8-bit CRC and compares the result with the checksum byte that the image carries in its final word.

Images come in two lengths. The block first assumes the short length. If the checksum does not match at that length, it restarts from word 0 and reads the long length of 220 words. It reports failure only when both lengths fail. When it finishes, it gives a one-cycle done pulse together with a pass or fail flag, the length that was accepted and the revision byte of the image. These results stay fixed until the next accepted start.

Top module: `cfg_image_crc_check`

## Requirements
- R1: The byte update is the reflected form of the generator x^8+x^7+x^6+x^4+x^2+1. XOR the byte into the register, then do eight right shifts, each one XORing 0xAB when the bit shifted out is 1. Updating a register of 0x00 with the bytes 0x01, 0x02 and 0x03 gives 0xF7, 0xB9 and 0x4E.
- R2: The register starts at 0xFF for every length attempt. Each word before the last is folded in two steps: bits 7:0 first, then bits 15:8.
- R3: Only bits 7:0 of the final word enter the CRC. The register is then XORed with 0xFF and compared with bits 15:8 of that same word.
- R4: `revision` reports bits 7:0 of the final word of the length that was accepted. After a double failure it reports bits 7:0 of the final word of the long length.
- R5: The first attempt reads SMALL_WORDS words (default 64). If it matches, `pass`=1 and `size_sel`=0, and no further reads are issued. No read address ever reaches LARGE_WORDS.
- R6: On a mismatch at the short length, the block restarts at word 0 and reads LARGE_WORDS words (220). A match there gives `pass`=1 and `size_sel`=1.
- R7: When both lengths mismatch, the block reports `fail`=1, `pass`=0 and `size_sel`=1.
- R8: `done` is high for exactly one cycle per accepted start. `pass` and `fail` are never high together. `pass`, `fail`, `size_sel` and `revision` change only on the `done` cycle or on the cycle after an accepted start, which clears all four to 0.
- R9: A start pulse that arrives while `busy` is high is ignored. The run in progress completes with unchanged results and one `done`.
- R10: After reset, `rd_en`, `busy`, `done`, `pass`, `fail` and `size_sel` are 0 and `revision` is 0x00.
- R11: Each attempt requests addresses 0, 1, 2, ... on consecutive cycles. Each read's data is consumed RD_LAT cycles after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a validation when idle |
| rd_en | output | 1 | Word read request |
| rd_addr | output | $clog2(LARGE_WORDS) | Word address of the request |
| rd_data | input | 16 | Word returned RD_LAT cycles after the request |
| busy | output | 1 | A validation is in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Image checksum matched |
| fail | output | 1 | Both lengths mismatched |
| size_sel | output | 1 | 0 = short length, 1 = long length |
| revision | output | 8 | Revision byte of the reported image |

## Verification
The bench targets the short-length mismatch that must trigger a second pass. A design that stopped there would report fail with only 64 reads. A design that forgot to reseed the register would reject a good long image. Images with unequal low and high bytes catch a swapped byte order. A checksum off by a single bit catches a missing final inversion or a final high byte folded into the CRC. Both of these would flip the pass result. A start pulse during a run, followed by a short-length pass after a long-length one, shows whether the block restarts mid-stream or carries old results over. A restart would change the read count. Stale results would leave `size_sel` or `revision` wrong.

// File: rtl/cfgcrc_pkg.sv
package cfgcrc_pkg;
  localparam int WORD_W         = 16;
  localparam int BYTE_W         = 8;
  localparam int BYTES_PER_WORD = WORD_W / BYTE_W;

  localparam logic [7:0] CRC_POLY_REV = 8'hAB;
  localparam logic [7:0] CRC_SEED     = 8'hFF;
  localparam logic [7:0] CRC_XOR_OUT  = 8'hFF;

  typedef logic [7:0] crc_lut_t [256];

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SMALL = 2'd1,
    PH_LARGE = 2'd2
  } phase_t;

  // One byte through the reflected generator, bit-serial form.
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c ^ b;
    for (int i = 0; i < 8; i++) begin
      x = x[0] ? ((x >> 1) ^ CRC_POLY_REV) : (x >> 1);
    end
    return x;
  endfunction

  // Full 256-entry lookup, computed at elaboration.
  function automatic crc_lut_t crc8_lut();
    crc_lut_t t;
    for (int i = 0; i < 256; i++) begin
      t[i] = crc8_step(8'h00, 8'(i));
    end
    return t;
  endfunction
endpackage

// File: rtl/cfgcrc_byte_step.sv
module cfgcrc_byte_step
  import cfgcrc_pkg::*;
#(
  parameter bit USE_LUT = 1'b1
) (
  input  logic [7:0] crc_in,
  input  logic [7:0] data_in,
  output logic [7:0] crc_out
);
  generate
    if (USE_LUT) begin : g_lut
      localparam crc_lut_t LUT = crc8_lut();
      assign crc_out = LUT[crc_in ^ data_in];
    end else begin : g_bits
      assign crc_out = crc8_step(crc_in, data_in);
    end
  endgenerate
endmodule

// File: rtl/cfgcrc_fetch.sv
module cfgcrc_fetch #(
  parameter int SMALL_WORDS = 64,
  parameter int LARGE_WORDS = 220,
  parameter int RD_LAT      = 2,
  parameter int AW          = $clog2(LARGE_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kick,
  input  logic          kick_large,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          data_vld
);
  localparam int CW = $clog2(LARGE_WORDS + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en  <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
    end else if (kick) begin
      rd_en  <= 1'b1;
      cnt_q  <= '0;
      last_q <= kick_large ? CW'(LARGE_WORDS - 1) : CW'(SMALL_WORDS - 1);
    end else if (rd_en) begin
      if (cnt_q == last_q) rd_en <= 1'b0;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rd_addr = cnt_q[AW-1:0];

  // Request-valid pipeline matched to the memory latency.
  generate
    if (RD_LAT == 1) begin : g_lat1
      logic vld_q;
      always_ff @(posedge clk) begin
        if (rst) vld_q <= 1'b0;
        else     vld_q <= rd_en;
      end
      assign data_vld = vld_q;
    end else begin : g_latn
      logic [RD_LAT-1:0] vld_q;
      always_ff @(posedge clk) begin
        if (rst) vld_q <= '0;
        else     vld_q <= {vld_q[RD_LAT-2:0], rd_en};
      end
      assign data_vld = vld_q[RD_LAT-1];
    end
  endgenerate
endmodule

// File: rtl/cfgcrc_ctrl.sv
module cfgcrc_ctrl
  import cfgcrc_pkg::*;
#(
  parameter int SMALL_WORDS = 64,
  parameter int LARGE_WORDS = 220
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       data_vld,
  input  logic [7:0] word_lo,
  input  logic [7:0] word_hi,
  input  logic [7:0] crc_after_lo,
  input  logic [7:0] crc_after_word,
  output logic [7:0] crc_q,
  output logic       kick,
  output logic       kick_large,
  output logic       busy,
  output logic       done,
  output logic       pass,
  output logic       fail,
  output logic       size_sel,
  output logic [7:0] revision
);
  localparam int CW = $clog2(LARGE_WORDS + 1);

  phase_t        ph_q;
  logic [CW-1:0] rx_q;
  logic [CW-1:0] last_idx;
  logic          sum_ok;

  assign last_idx = (ph_q == PH_LARGE) ? CW'(LARGE_WORDS - 1) : CW'(SMALL_WORDS - 1);
  assign sum_ok   = ((crc_after_lo ^ CRC_XOR_OUT) == word_hi);
  assign busy     = (ph_q != PH_IDLE);

  always_ff @(posedge clk) begin
    kick <= 1'b0;
    done <= 1'b0;
    if (rst) begin
      ph_q       <= PH_IDLE;
      crc_q      <= CRC_SEED;
      rx_q       <= '0;
      kick_large <= 1'b0;
      pass       <= 1'b0;
      fail       <= 1'b0;
      size_sel   <= 1'b0;
      revision   <= 8'h00;
    end else begin
      case (ph_q)
        PH_IDLE: begin
          if (start) begin
            ph_q       <= PH_SMALL;
            crc_q      <= CRC_SEED;
            rx_q       <= '0;
            kick       <= 1'b1;
            kick_large <= 1'b0;
            pass       <= 1'b0;
            fail       <= 1'b0;
            size_sel   <= 1'b0;
            revision   <= 8'h00;
          end
        end
        default: begin
          if (data_vld) begin
            if (rx_q != last_idx) begin
              crc_q <= crc_after_word;
              rx_q  <= rx_q + 1'b1;
            end else if (sum_ok) begin
              pass     <= 1'b1;
              size_sel <= (ph_q == PH_LARGE);
              revision <= word_lo;
              done     <= 1'b1;
              ph_q     <= PH_IDLE;
            end else if (ph_q == PH_SMALL) begin
              ph_q       <= PH_LARGE;
              crc_q      <= CRC_SEED;
              rx_q       <= '0;
              kick       <= 1'b1;
              kick_large <= 1'b1;
            end else begin
              fail     <= 1'b1;
              size_sel <= 1'b1;
              revision <= word_lo;
              done     <= 1'b1;
              ph_q     <= PH_IDLE;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cfg_image_crc_check.sv
module cfg_image_crc_check
  import cfgcrc_pkg::*;
#(
  parameter int SMALL_WORDS = 64,
  parameter int LARGE_WORDS = 220,
  parameter int RD_LAT      = 2,
  parameter bit USE_LUT     = 1'b1
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start,
  output logic                           rd_en,
  output logic [$clog2(LARGE_WORDS)-1:0] rd_addr,
  input  logic [WORD_W-1:0]              rd_data,
  output logic                           busy,
  output logic                           done,
  output logic                           pass,
  output logic                           fail,
  output logic                           size_sel,
  output logic [7:0]                     revision
);
  localparam int AW = $clog2(LARGE_WORDS);

  logic       data_vld;
  logic       kick;
  logic       kick_large;
  logic [7:0] crc_q;
  logic [BYTES_PER_WORD:0][7:0] chain;

  cfgcrc_fetch #(
    .SMALL_WORDS(SMALL_WORDS),
    .LARGE_WORDS(LARGE_WORDS),
    .RD_LAT     (RD_LAT),
    .AW         (AW)
  ) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .kick      (kick),
    .kick_large(kick_large),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .data_vld  (data_vld)
  );

  // Low byte first, then each higher byte, chained combinationally.
  assign chain[0] = crc_q;
  generate
    for (genvar b = 0; b < BYTES_PER_WORD; b++) begin : g_byte
      cfgcrc_byte_step #(.USE_LUT(USE_LUT)) u_step (
        .crc_in (chain[b]),
        .data_in(rd_data[b*BYTE_W +: BYTE_W]),
        .crc_out(chain[b+1])
      );
    end
  endgenerate

  cfgcrc_ctrl #(
    .SMALL_WORDS(SMALL_WORDS),
    .LARGE_WORDS(LARGE_WORDS)
  ) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .data_vld      (data_vld),
    .word_lo       (rd_data[7:0]),
    .word_hi       (rd_data[WORD_W-1 -: BYTE_W]),
    .crc_after_lo  (chain[1]),
    .crc_after_word(chain[BYTES_PER_WORD]),
    .crc_q         (crc_q),
    .kick          (kick),
    .kick_large    (kick_large),
    .busy          (busy),
    .done          (done),
    .pass          (pass),
    .fail          (fail),
    .size_sel      (size_sel),
    .revision      (revision)
  );
endmodule

// File: rtl/cfgcrc_sva.sv
module cfgcrc_sva #(
  parameter int LARGE_WORDS = 220
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           start,
  input logic                           rd_en,
  input logic [$clog2(LARGE_WORDS)-1:0] rd_addr,
  input logic                           busy,
  input logic                           done,
  input logic                           pass,
  input logic                           fail,
  input logic                           size_sel,
  input logic [7:0]                     revision
);
  p_pass_fail_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(pass && fail));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(start)) |-> ($stable(pass) && $stable(fail) &&
                                 $stable(size_sel) && $stable(revision)));

  p_fail_long_r7: assert property (@(posedge clk) disable iff (rst)
    fail |-> size_sel);

  p_addr_bound_r5: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (int'(rd_addr) < LARGE_WORDS));

  p_addr_first_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en) |-> (rd_addr == '0));

  p_addr_step_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

  p_read_busy_r9: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> busy);
endmodule

bind cfg_image_crc_check cfgcrc_sva #(.LARGE_WORDS(LARGE_WORDS)) u_sva (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .busy    (busy),
  .done    (done),
  .pass    (pass),
  .fail    (fail),
  .size_sel(size_sel),
  .revision(revision)
);

// File: tb/cfg_image_crc_check_tb.sv
module cfg_image_crc_check_tb;
  localparam int SW  = 64;
  localparam int LW  = 220;
  localparam int LAT = 3;
  localparam int AW  = $clog2(LW);

  typedef struct packed {
    logic        ok;
    logic        bad;
    logic        big;
    logic [7:0]  rev;
    logic [15:0] reads;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic [15:0]   rd_data;
  logic          busy, done, pass, fail, size_sel;
  logic [7:0]    revision;

  always #10 clk = ~clk;

  cfg_image_crc_check #(
    .SMALL_WORDS(SW), .LARGE_WORDS(LW), .RD_LAT(LAT), .USE_LUT(1'b1)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .done(done), .pass(pass), .fail(fail),
    .size_sel(size_sel), .revision(revision)
  );

  // Memory model: fixed latency of LAT cycles.
  logic [15:0] mem  [LW];
  logic [15:0] pipe [LAT];
  always @(posedge clk) begin
    pipe[0] <= mem[(int'(rd_addr) < LW) ? int'(rd_addr) : 0];
    for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
  end
  assign rd_data = pipe[LAT-1];

  exp_t sb_q[$];
  int   n_chk = 0, n_bad = 0, n_done = 0, n_runs = 0, rd_seen = 0;
  logic h_pass, h_fail, h_size;
  logic [7:0] h_rev;

  task automatic chk(string req, string what, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] ref_byte(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c ^ b;
    for (int i = 0; i < 8; i++) x = x[0] ? ((x >> 1) ^ 8'hAB) : (x >> 1);
    return x;
  endfunction

  function automatic logic [7:0] ref_crc(input int n);
    logic [7:0] c;
    c = 8'hFF;
    for (int w = 0; w < n - 1; w++) begin
      c = ref_byte(c, mem[w][7:0]);
      c = ref_byte(c, mem[w][15:8]);
    end
    c = ref_byte(c, mem[n-1][7:0]);
    return c ^ 8'hFF;
  endfunction

  task automatic fill_rand(input logic [31:0] seed);
    logic [31:0] x;
    x = seed;
    for (int i = 0; i < LW; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      mem[i] = x[15:0];
    end
  endtask

  task automatic fill_const(input logic [15:0] v);
    for (int i = 0; i < LW; i++) mem[i] = v;
  endtask

  task automatic seal(input int n, input logic [7:0] rev, input bit good);
    logic [7:0] c;
    mem[n-1][7:0] = rev;
    c = ref_crc(n);
    mem[n-1][15:8] = good ? c : (c ^ 8'h5A);
  endtask

  // Driver: derive expectation from the image, push it, pulse start.
  task automatic run(input bit extra_start);
    exp_t e;
    bit s_ok, l_ok;
    s_ok = (ref_crc(SW) == mem[SW-1][15:8]);
    l_ok = (ref_crc(LW) == mem[LW-1][15:8]);
    e.ok    = s_ok || l_ok;
    e.bad   = !(s_ok || l_ok);
    e.big   = !s_ok;
    e.rev   = s_ok ? mem[SW-1][7:0] : mem[LW-1][7:0];
    e.reads = s_ok ? 16'(SW) : 16'(SW + LW);
    sb_q.push_back(e);
    n_runs++;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    if (extra_start) begin
      repeat (10) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    while (sb_q.size() != 0) @(negedge clk);
    repeat (25) @(negedge clk);
    // R8: results hold well after the done pulse
    chk("R8", "held pass", int'(pass), int'(h_pass));
    chk("R8", "held fail", int'(fail), int'(h_fail));
    chk("R8", "held size_sel", int'(size_sel), int'(h_size));
    chk("R8", "held revision", int'(revision), int'(h_rev));
  endtask

  // Monitor: pop expectations as results appear.
  initial begin
    exp_t e;
    logic prev_done;
    prev_done = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (rd_en) rd_seen++;
        if (prev_done) chk("R8", "done width", int'(done), 0);
        if (done) begin
          n_done++;
          if (sb_q.size() == 0) begin
            chk("R9", "unexpected done", 1, 0);
          end else begin
            e = sb_q.pop_front();
            chk("R5 R6", "pass", int'(pass), int'(e.ok));
            chk("R7", "fail", int'(fail), int'(e.bad));
            chk("R5 R6 R7", "size_sel", int'(size_sel), int'(e.big));
            chk("R4", "revision", int'(revision), int'(e.rev));
            chk("R11 R6", "read count", rd_seen, int'(e.reads));
          end
          h_pass = pass; h_fail = fail; h_size = size_sel; h_rev = revision;
          rd_seen = 0;
        end
        prev_done = done;
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    fill_const(16'h0000);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R10: reset state
    chk("R10", "rd_en", int'(rd_en), 0);
    chk("R10", "busy", int'(busy), 0);
    chk("R10", "done", int'(done), 0);
    chk("R10", "pass/fail/size", int'({pass, fail, size_sel}), 0);
    chk("R10", "revision", int'(revision), 0);

    // R1: reference table spot values
    chk("R1", "T[1]", int'(ref_byte(8'h00, 8'h01)), 8'hF7);
    chk("R1", "T[2]", int'(ref_byte(8'h00, 8'h02)), 8'hB9);
    chk("R1", "T[3]", int'(ref_byte(8'h00, 8'h03)), 8'h4E);

    // R6: short length broken, long length good
    fill_rand(32'h1234_5678);
    seal(SW, 8'h11, 1'b0);
    seal(LW, 8'h08, 1'b1);
    run(1'b0);

    // R5 R2: short length good; results from the earlier long run cleared
    fill_rand(32'hCAFE_0001);
    seal(SW, 8'h05, 1'b1);
    run(1'b0);

    // R7: both lengths broken
    fill_rand(32'h0BAD_F00D);
    seal(SW, 8'h21, 1'b0);
    seal(LW, 8'h33, 1'b0);
    run(1'b0);

    // R7 R4: erased memory, all ones
    fill_const(16'hFFFF);
    run(1'b0);

    // R2 R9: unequal byte halves, and a start during the run
    for (int i = 0; i < LW; i++) mem[i] = 16'((i * 16'h0103) ^ 16'h5A00);
    seal(SW, 8'h2A, 1'b1);
    run(1'b1);

    // R3: single-bit checksum error at short length, long length good
    fill_rand(32'h7777_AAAA);
    seal(SW, 8'h40, 1'b1);
    mem[SW-1][15:8] = mem[SW-1][15:8] ^ 8'h01;
    seal(LW, 8'hFF, 1'b1);
    run(1'b0);

    // R3: all-zero image, short length good
    fill_const(16'h0000);
    seal(SW, 8'h00, 1'b1);
    run(1'b0);

    // R9: exactly one done per accepted start
    chk("R9", "done count", n_done, n_runs);

    summary();
    $finish;
  end
endmodule